// File: doc/BRIEF.md
# Store-to-Load Forwarding Checker

An executing load is checked against the older stores still held in the store queue. The load supplies its address, its size in bytes and the store-queue index it was given at dispatch. The checker then walks the store queue one entry per cycle. It moves toward older stores, wraps around at the bottom, and stops when it reaches the writeback pointer. The first store that touches the load's bytes decides the outcome. If that store holds every byte the load needs, the load gets the store's data, aligned to the load address. If the store holds only some of the bytes, the load must replay, so the result is a stall. If no such store is found, the load goes to the cache and uses a cache port.

The checker reads the store queue through a one-entry read port: it drives an index and receives that entry's fields in the same cycle. It also keeps a single stall record. The record holds the oldest load that has hit a partial overlap and the sequence number of the store that blocks it. When that store finishes writeback, the record is released and a one-cycle pulse reports the release.

Top module: `store_fwd_check`

## Requirements
- R1: After reset, `done`, `busy`, `stalled` and `stall_clear` are low.
- R2: A request is taken when `req_valid` is high and `busy` is low. Scan step 1 happens in the request cycle. If the current index equals `wb_ptr`, the step ends the scan as a miss. Otherwise the step examines entry (index − 1) modulo the depth, and that entry becomes the index for the next step. Each step takes one cycle. The cycle in which step n decides the result is followed by `done` high for exactly one cycle, n cycles after the request was sampled.
- R3: An entry with size 0, or with its uncacheable flag set, is stepped over as if it did not overlap.
- R4: An entry contains the load when load start ≥ store start and load start + load size ≤ store start + store size. A containing entry gives a forward result. `fwd_data` byte b (bits 8b+7:8b) is then store data byte (load start − store start + b) for every b below the load size, and zero for every higher b. `fwd_data` is zero with every result that is not a forward.
- R5: An entry overlaps the load when load start < store end and load end > store start, with both ends exclusive. An entry that overlaps the load but does not contain it gives a stall result and forwards nothing.
- R6: The first deciding entry reached, which is the youngest of the older stores, sets the result, even when older entries would also match.
- R7: A miss result raises `port_used` in the same cycle as `done`. `port_used` is low at every other time.
- R8: A stall result updates the stall record only when no load is stalled, or when the request's sequence number is numerically smaller (older) than that of the recorded load. An update stores the blocking store's sequence number in `stall_store_seq` and the load's queue index in `stall_lq_idx`, and sets `stalled`. Any other stall result leaves the record unchanged.
- R9: While `stalled` is high, a `wb_done` pulse whose `wb_done_seq` equals `stall_store_seq` drops `stalled` and raises `stall_clear` for one cycle, both in the following cycle. A pulse with any other sequence number has no effect.
- R10: While `done` is high, exactly one of `res_fwd`, `res_stall` and `res_miss` is high. All three are low while `done` is low.
- R11: A request raised while `busy` is high is ignored. The scan in progress completes with its own result, and no extra `done` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Load check request |
| req_addr | input | AW | Load start address |
| req_size | input | SZW | Load size in bytes, 1 to NB |
| req_sq_idx | input | IW | Store-queue index recorded at dispatch |
| req_lq_idx | input | LQW | Load-queue index of the load |
| req_seq | input | SEQW | Load sequence number (smaller is older) |
| wb_ptr | input | IW | Store writeback pointer, where the scan ends |
| sq_rd_idx | output | IW | Store-queue entry being examined |
| sq_addr | input | AW | Start address of the examined store |
| sq_size | input | SZW | Size of the examined store, 0 when empty |
| sq_nc | input | 1 | Examined store is uncacheable |
| sq_data | input | 8*NB | Data of the examined store, byte 0 lowest |
| sq_seq | input | SEQW | Sequence number of the examined store |
| wb_done | input | 1 | A store completed writeback |
| wb_done_seq | input | SEQW | Sequence number of that store |
| busy | output | 1 | Scan in progress beyond its first step |
| done | output | 1 | Result valid, one cycle |
| res_fwd | output | 1 | Result: full forward |
| res_stall | output | 1 | Result: partial overlap, load replays |
| res_miss | output | 1 | Result: no match, go to memory |
| fwd_data | output | 8*NB | Forwarded bytes |
| port_used | output | 1 | A cache port is taken this cycle |
| stalled | output | 1 | Stall record valid |
| stall_store_seq | output | SEQW | Blocking store of the recorded load |
| stall_lq_idx | output | LQW | Queue index of the recorded load |
| stall_clear | output | 1 | Stall record released, one cycle |

## Verification
If the scan index is wrong, the scan examines the wrong entries. The result then comes from the wrong store, or `done` arrives in a different cycle than the step count predicts. Every scan result is checked for its class, its data and the exact cycle of `done`. If the stall record is corrupted, `stall_store_seq` and `stall_lq_idx` show it in the cycle after the stall result. If the release compares against the wrong sequence number, `stall_clear` fires on the wrong writeback pulse or stays silent on the right one, and this shows one cycle after `wb_done`.

// File: rtl/store_fwd_check.sv
module store_fwd_check #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int NB    = 8,
  parameter int SEQW  = 16,
  parameter int LQW   = 4,
  localparam int IW   = $clog2(DEPTH),
  localparam int SZW  = $clog2(NB) + 1,
  localparam int DW   = 8 * NB
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [AW-1:0]   req_addr,
  input  logic [SZW-1:0]  req_size,
  input  logic [IW-1:0]   req_sq_idx,
  input  logic [LQW-1:0]  req_lq_idx,
  input  logic [SEQW-1:0] req_seq,
  input  logic [IW-1:0]   wb_ptr,
  output logic [IW-1:0]   sq_rd_idx,
  input  logic [AW-1:0]   sq_addr,
  input  logic [SZW-1:0]  sq_size,
  input  logic            sq_nc,
  input  logic [DW-1:0]   sq_data,
  input  logic [SEQW-1:0] sq_seq,
  input  logic            wb_done,
  input  logic [SEQW-1:0] wb_done_seq,
  output logic            busy,
  output logic            done,
  output logic            res_fwd,
  output logic            res_stall,
  output logic            res_miss,
  output logic [DW-1:0]   fwd_data,
  output logic            port_used,
  output logic            stalled,
  output logic [SEQW-1:0] stall_store_seq,
  output logic [LQW-1:0]  stall_lq_idx,
  output logic            stall_clear
);
  localparam int SHW = $clog2(NB);

  logic [IW-1:0]   idx_q;
  logic [AW-1:0]   addr_q;
  logic [SZW-1:0]  size_q;
  logic [LQW-1:0]  lq_q;
  logic [SEQW-1:0] seq_q;
  logic [SEQW-1:0] stall_ld_seq_q;

  wire go     = req_valid & ~busy;
  wire active = busy | go;

  wire [IW-1:0]   cur_idx = busy ? idx_q  : req_sq_idx;
  wire [AW-1:0]   ld_addr = busy ? addr_q : req_addr;
  wire [SZW-1:0]  ld_size = busy ? size_q : req_size;
  wire [LQW-1:0]  ld_lq   = busy ? lq_q   : req_lq_idx;
  wire [SEQW-1:0] ld_seq  = busy ? seq_q  : req_seq;

  assign sq_rd_idx = (cur_idx == '0) ? IW'(DEPTH - 1) : cur_idx - 1'b1;

  wire at_wb = (cur_idx == wb_ptr);
  wire [AW:0] ld_lo = {1'b0, ld_addr};
  wire [AW:0] ld_hi = ld_lo + (AW+1)'(ld_size);
  wire [AW:0] st_lo = {1'b0, sq_addr};
  wire [AW:0] st_hi = st_lo + (AW+1)'(sq_size);
  wire live    = (sq_size != '0) & ~sq_nc;
  wire contain = live & (ld_lo >= st_lo) & (ld_hi <= st_hi);
  wire overlap = live & (ld_lo < st_hi) & (ld_hi > st_lo);

  wire dec_miss  = active & at_wb;
  wire dec_fwd   = active & ~at_wb & contain;
  wire dec_stall = active & ~at_wb & overlap & ~contain;
  wire decide    = dec_miss | dec_fwd | dec_stall;

  wire [AW:0]      ofs     = ld_lo - st_lo;
  wire [SHW-1:0]   shift   = ofs[SHW-1:0];
  wire [DW-1:0]    shifted = sq_data >> {shift, 3'b000};
  logic [DW-1:0]   fbytes;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign fbytes[8*b +: 8] = (SZW'(b) < ld_size) ? shifted[8*b +: 8] : 8'h00;
  end

  wire take_stall = dec_stall & (~stalled | (ld_seq < stall_ld_seq_q));
  wire clr_hit    = stalled & wb_done & (wb_done_seq == stall_store_seq);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx_q <= '0;
      addr_q <= '0;
      size_q <= '0;
      lq_q <= '0;
      seq_q <= '0;
      done <= 1'b0;
      res_fwd <= 1'b0;
      res_stall <= 1'b0;
      res_miss <= 1'b0;
      fwd_data <= '0;
      stalled <= 1'b0;
      stall_store_seq <= '0;
      stall_lq_idx <= '0;
      stall_ld_seq_q <= '0;
      stall_clear <= 1'b0;
    end else begin
      done      <= decide;
      res_fwd   <= dec_fwd;
      res_stall <= dec_stall;
      res_miss  <= dec_miss;
      fwd_data  <= dec_fwd ? fbytes : '0;
      if (go) begin
        addr_q <= req_addr;
        size_q <= req_size;
        lq_q   <= req_lq_idx;
        seq_q  <= req_seq;
      end
      if (active && !decide) begin
        busy  <= 1'b1;
        idx_q <= sq_rd_idx;
      end else if (decide) begin
        busy <= 1'b0;
      end
      stall_clear <= 1'b0;
      if (take_stall) begin
        stalled         <= 1'b1;
        stall_store_seq <= sq_seq;
        stall_lq_idx    <= ld_lq;
        stall_ld_seq_q  <= ld_seq;
      end else if (clr_hit) begin
        stalled     <= 1'b0;
        stall_clear <= 1'b1;
      end
    end
  end

  assign port_used = done & res_miss;

  // R10
  result_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($countones({res_fwd, res_stall, res_miss}) == 1));

  // R10
  result_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ({res_fwd, res_stall, res_miss} == 3'b000));

  // R4
  fwd_data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !res_fwd) |-> (fwd_data == '0));

  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && res_stall) |-> $stable(stall_store_seq));

  // R9
  stall_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_clear |-> (!stalled && $past(stalled)));
endmodule

// File: tb/test_store_fwd_check.sv
module test_store_fwd_check;
  localparam int DEPTH = 8, AW = 16, NB = 8, SEQW = 16, LQW = 4;
  localparam int IW = 3, SZW = 4, DW = 64;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic [AW-1:0] req_addr = 0;
  logic [SZW-1:0] req_size = 0;
  logic [IW-1:0] req_sq_idx = 0, wb_ptr = 0;
  logic [LQW-1:0] req_lq_idx = 0;
  logic [SEQW-1:0] req_seq = 0, wb_done_seq = 0;
  logic wb_done = 0;
  logic [IW-1:0] sq_rd_idx;
  logic [AW-1:0] sq_addr;
  logic [SZW-1:0] sq_size;
  logic sq_nc;
  logic [DW-1:0] sq_data, fwd_data;
  logic [SEQW-1:0] sq_seq, stall_store_seq;
  logic busy, done, res_fwd, res_stall, res_miss, port_used, stalled, stall_clear;
  logic [LQW-1:0] stall_lq_idx;

  logic [AW-1:0] m_addr [DEPTH];
  logic [SZW-1:0] m_size [DEPTH];
  logic m_nc [DEPTH];
  logic [DW-1:0] m_data [DEPTH];
  logic [SEQW-1:0] m_seq [DEPTH];

  assign sq_addr = m_addr[sq_rd_idx];
  assign sq_size = m_size[sq_rd_idx];
  assign sq_nc   = m_nc[sq_rd_idx];
  assign sq_data = m_data[sq_rd_idx];
  assign sq_seq  = m_seq[sq_rd_idx];

  store_fwd_check i_store_fwd_check (
    .clk, .rst_n, .req_valid, .req_addr, .req_size, .req_sq_idx, .req_lq_idx,
    .req_seq, .wb_ptr, .sq_rd_idx, .sq_addr, .sq_size, .sq_nc, .sq_data,
    .sq_seq, .wb_done, .wb_done_seq, .busy, .done, .res_fwd, .res_stall,
    .res_miss, .fwd_data, .port_used, .stalled, .stall_store_seq,
    .stall_lq_idx, .stall_clear);

  always #2 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, pops = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int q_res[$];
  logic [DW-1:0] q_data[$];
  int q_cyc[$];
  string q_tag[$];

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q_res.size() == 0) begin
        check("R11 unexpected done", 1, 0);
      end else begin
        automatic int er = q_res.pop_front();
        automatic logic [DW-1:0] ed = q_data.pop_front();
        automatic int ec = q_cyc.pop_front();
        automatic string t = q_tag.pop_front();
        check({t, " result"}, {61'd0, res_stall, res_fwd, res_miss},
              (er == 0) ? 64'd1 : (er == 1) ? 64'd2 : 64'd4);
        check({t, " data"}, fwd_data, ed);
        check({t, " done cycle"}, cyc, ec);
        check({t, " R7 port_used"}, port_used, er == 0);
      end
      pops++;
    end
  end

  task automatic clear_sq();
    for (int i = 0; i < DEPTH; i++) begin
      m_addr[i] = 0; m_size[i] = 0; m_nc[i] = 0; m_data[i] = 0; m_seq[i] = 0;
    end
  endtask

  task automatic set_ent(int i, int a, int s, bit nc, logic [DW-1:0] d, int sq);
    m_addr[i] = AW'(a); m_size[i] = SZW'(s); m_nc[i] = nc;
    m_data[i] = d; m_seq[i] = SEQW'(sq);
  endtask

  task automatic send(string tag, int a, int s, int sqi, int lq, int sq, bit poke);
    int idx = sqi, lat = 1, res = 0;
    logic [DW-1:0] d = 0;
    int target = pops + 1;
    forever begin
      int e, ll, lh, sl, sh;
      if (idx == int'(wb_ptr)) begin res = 0; break; end
      e = (idx + DEPTH - 1) % DEPTH;
      ll = a; lh = a + s; sl = m_addr[e]; sh = m_addr[e] + m_size[e];
      if (m_size[e] != 0 && !m_nc[e]) begin
        if (ll >= sl && lh <= sh) begin
          res = 1;
          for (int b = 0; b < s; b++) d[8*b +: 8] = m_data[e][8*(ll - sl + b) +: 8];
          break;
        end
        if (ll < sh && lh > sl) begin res = 2; break; end
      end
      idx = e; lat++;
    end
    @(negedge clk);
    q_res.push_back(res); q_data.push_back(d); q_cyc.push_back(cyc + lat); q_tag.push_back(tag);
    req_valid = 1; req_addr = AW'(a); req_size = SZW'(s); req_sq_idx = IW'(sqi);
    req_lq_idx = LQW'(lq); req_seq = SEQW'(sq);
    @(negedge clk);
    req_valid = 0;
    if (poke) begin
      req_valid = 1; req_addr = 16'h0900; req_size = 1; req_sq_idx = 0;
      @(negedge clk);
      req_valid = 0;
    end
    while (pops < target) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_wb(int sq);
    @(negedge clk);
    wb_done = 1; wb_done_seq = SEQW'(sq);
    @(negedge clk);
    wb_done = 0;
  endtask

  initial begin
    #100000;
    check("watchdog", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clear_sq();
    repeat (3) @(negedge clk);
    check("R1 done", done, 0);
    check("R1 busy", busy, 0);
    check("R1 stalled", stalled, 0);
    check("R1 stall_clear", stall_clear, 0);
    rst_n = 1;
    @(negedge clk);

    set_ent(0, 'h100, 8, 0, 64'h8877665544332211, 10);
    wb_ptr = 0;
    send("R4 exact forward", 'h100, 8, 1, 1, 50, 0);
    send("R4 shifted forward", 'h103, 2, 1, 1, 51, 0);
    send("R4 masked forward", 'h101, 5, 1, 1, 52, 0);

    clear_sq();
    set_ent(0, 'h200, 4, 0, 64'hAABBCCDD, 11);
    send("R2 miss after scan", 'h300, 4, 1, 1, 53, 0);
    send("R2 index at wb_ptr", 'h200, 4, 0, 1, 54, 0);
    set_ent(0, 'h800, 4, 0, 64'h1, 12);
    send("R5 adjacent no overlap", 'h7FC, 4, 1, 1, 55, 0);

    clear_sq();
    set_ent(2, 'h400, 0, 0, 64'hDEAD, 13);
    set_ent(1, 'h400, 8, 1, 64'hBEEF, 14);
    set_ent(0, 'h400, 8, 0, 64'h0102030405060708, 15);
    send("R3 skip empty and uncacheable", 'h400, 4, 3, 1, 56, 0);

    clear_sq();
    set_ent(1, 'h500, 4, 0, 64'h44332211, 16);
    set_ent(0, 'h500, 8, 0, 64'hFFEEDDCCBBAA9988, 17);
    send("R6 youngest wins", 'h500, 2, 2, 1, 57, 0);

    clear_sq();
    wb_ptr = 5;
    set_ent(0, 'h10, 4, 0, 64'h1, 18);
    set_ent(7, 'h20, 4, 0, 64'h2, 19);
    set_ent(6, 'h30, 8, 0, 64'h1122334455667788, 20);
    send("R11 R2 wrap scan with busy request", 'h32, 4, 1, 1, 58, 1);

    clear_sq();
    wb_ptr = 0;
    set_ent(0, 'h600, 4, 0, 64'h1, 40);
    send("R5 partial stall", 'h602, 4, 1, 3, 100, 0);
    check("R8 stalled set", stalled, 1);
    check("R8 store seq", stall_store_seq, 40);
    check("R8 lq idx", stall_lq_idx, 3);
    m_seq[0] = 41;
    send("R5 younger partial", 'h602, 4, 1, 5, 120, 0);
    check("R8 younger keeps seq", stall_store_seq, 40);
    check("R8 younger keeps lq", stall_lq_idx, 3);
    m_seq[0] = 42;
    send("R5 older partial", 'h5FE, 4, 1, 6, 90, 0);
    check("R8 older takes seq", stall_store_seq, 42);
    check("R8 older takes lq", stall_lq_idx, 6);

    pulse_wb(40);
    check("R9 other seq no clear", stall_clear, 0);
    check("R9 other seq stalled", stalled, 1);
    pulse_wb(42);
    check("R9 clear pulse", stall_clear, 1);
    check("R9 stalled dropped", stalled, 0);
    @(negedge clk);
    check("R9 pulse one cycle", stall_clear, 0);

    m_seq[0] = 43;
    send("R8 capture when idle", 'h603, 2, 1, 7, 200, 0);
    check("R8 idle capture seq", stall_store_seq, 43);
    check("R8 idle capture lq", stall_lq_idx, 7);

    repeat (4) @(negedge clk);
    check("R10 no stray done", q_res.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule